// File: doc/BRIEF.md
# DRAM Host Command Sequencer

This block plays back a short, software-written list of raw DRAM commands once after reset, the kind of list used to bring a DDR2 device through power-up, precharge, refresh and mode-register loading before normal traffic is allowed. Each of the sixteen command slots is two 32-bit words written over a simple register bus. The first word holds the 24-bit control-pin pattern in its low bits and extra upper address or bank bits in its top byte. The second word holds eleven low address bits and a post-command wait, stored as the required clock count minus two.

Software fills the slots and writes the issue register with the index of the last slot to run plus a valid flag. It then sets the start bit in the control register. The sequencer walks the slots from index 0 upward. It presents each slot's pattern for one clock with a strobe, drives the idle NOP pattern until that slot's wait has elapsed, and then moves on. After the final slot's wait it clears the valid flag by itself. Software polls that flag and then sets the done bit, which releases the normal-traffic enable.

Top module: `dram_cmd_seq`

## Requirements
- R1: After reset the busy output and `traffic_en` are 0, `cmd_strobe` is 0, `cmd_pins` is the NOP pattern 24'hFFFFFF, and the control register (address 0) and the issue register (address 1) read 0.
- R2: Slot word A for slot i sits at address 6'h20+i and word B at 6'h30+i. While the sequencer is idle, each word reads back exactly the 32 bits last written.
- R3: A control write with bit 0 set, made while idle with the issue valid flag (bit 4 of address 1) set, runs slots 0 through the last index held in issue bits [3:0], in ascending order. Every slot is shown for exactly one clock with `cmd_strobe` high. In that clock `cmd_pins` equals word A [23:0], `cmd_addr_hi` equals word A [31:24] and `cmd_addr_lo` equals word B [10:0].
- R4: The strobe of a slot whose word B [31:11] holds D is followed by D+1 clocks with `cmd_strobe` low and `cmd_pins` at NOP. The next slot's strobe, or the end of the run, comes D+2 clocks after the strobe.
- R5: The issue valid flag and the busy bit (bit 0 of status address 2, and the `busy` port) read 1 for the whole run. Both drop together in the clock after the last slot's wait ends, and the last-index field keeps its value.
- R6: While busy, writes to the slot words, the issue register and the control register are ignored. This is visible in their read-back values after the run.
- R7: `traffic_en` is 1 only when the control done bit (bit 1 of address 0) is set and the sequencer is not busy. It stays 0 for the whole run.
- R8: Setting the start bit while the valid flag is 0 starts no run: busy stays 0 and no strobe appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| cmd_strobe | output | 1 | High in the single clock a slot is issued |
| cmd_pins | output | 24 | Control-pin pattern, NOP when not issuing |
| cmd_addr_hi | output | 8 | Upper address/bank bits of the issued slot |
| cmd_addr_lo | output | 11 | Low address bits of the issued slot |
| busy | output | 1 | Sequence running |
| traffic_en | output | 1 | Normal-traffic enable |

## Verification
A wrong slot index or a skipped slot shows up on `cmd_pins` at the very next strobe, since every slot carries a distinct pattern. A wait counter that is off by one moves every later strobe by a clock and moves the point where valid clears. The bench therefore compares the pins, strobe and busy in every clock of a run against a schedule it builds from the programmed delays. A state that fails to lock the registers during a run only shows after the run ends, so the registers are read back at that point.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam logic [23:0] PIN_NOP = 24'hFFFFFF;
  localparam int CTRL_ADDR   = 0;
  localparam int ISSUE_ADDR  = 1;
  localparam int STATUS_ADDR = 2;
  localparam int VALID_BIT   = 4;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } sq_state_t;
endpackage

// File: rtl/dcs_rst_sync.sv
module dcs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/dcs_slot_store.sv
module dcs_slot_store #(
  parameter int SLOTS = 16,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_a,
  input  logic             wr_b,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] bus_idx,
  input  logic [IDX_W-1:0] seq_idx,
  output logic [DW-1:0]    bus_a,
  output logic [DW-1:0]    bus_b,
  output logic [DW-1:0]    seq_a,
  output logic [DW-1:0]    seq_b
);
  logic [DW-1:0] word_a [SLOTS];
  logic [DW-1:0] word_b [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic en_a, en_b;
    assign en_a = wr_a && (wr_idx == IDX_W'(s));
    assign en_b = wr_b && (wr_idx == IDX_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_a[s] <= '0;
        word_b[s] <= '0;
      end else begin
        if (en_a) word_a[s] <= wdata;
        if (en_b) word_b[s] <= wdata;
      end
    end
  end

  assign bus_a = word_a[bus_idx];
  assign bus_b = word_b[bus_idx];
  assign seq_a = word_a[seq_idx];
  assign seq_b = word_b[seq_idx];
endmodule

// File: rtl/dcs_delay_timer.sv
module dcs_delay_timer #(
  parameter int W = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/dcs_seq_fsm.sv
module dcs_seq_fsm
  import dcs_pkg::*;
#(
  parameter int SLOTS = 16,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] last_idx,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic             tmr_dec,
  output logic [IDX_W-1:0] idx,
  output logic             strobe,
  output logic             finish,
  output logic             busy
);
  sq_state_t        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             st_en;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    finish   = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start) begin
          state_d = SQ_ISSUE;
          idx_d   = '0;
        end
      end
      SQ_ISSUE: begin
        tmr_load = 1'b1;
        state_d  = SQ_WAIT;
      end
      SQ_WAIT: begin
        if (tmr_zero) begin
          if (idx_q == last_idx) begin
            state_d = SQ_IDLE;
            finish  = 1'b1;
          end else begin
            state_d = SQ_ISSUE;
            idx_d   = idx_q + IDX_W'(1);
          end
        end else begin
          tmr_dec = 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  assign st_en = (state_d != state_q) || (idx_d != idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
    end else if (st_en) begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign idx    = idx_q;
  assign strobe = (state_q == SQ_ISSUE);
  assign busy   = (state_q != SQ_IDLE);
endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
  import dcs_pkg::*;
#(
  parameter int SLOTS   = 16,
  parameter int DW      = 32,
  parameter int PIN_W   = 24,
  parameter int LO_W    = 11,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int AW     = IDX_W + 2,
  localparam int HI_W   = DW - PIN_W,
  localparam int DLY_W  = DW - LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             cmd_strobe,
  output logic [PIN_W-1:0] cmd_pins,
  output logic [HI_W-1:0]  cmd_addr_hi,
  output logic [LO_W-1:0]  cmd_addr_lo,
  output logic             busy,
  output logic             traffic_en
);
  logic             rst_n_s;
  logic             slot_sel, half_b;
  logic [IDX_W-1:0] addr_idx;
  logic             wr_ok, wr_a, wr_b, wr_ctrl, wr_issue;
  logic [DW-1:0]    bus_a, bus_b, seq_a, seq_b;
  logic [IDX_W-1:0] seq_idx;
  logic             tmr_load, tmr_dec, tmr_zero, finish, start;

  logic             ctrl_start_q, ctrl_done_q;
  logic [IDX_W-1:0] last_q;
  logic             issue_valid_q;
  logic             valid_d, valid_en;

  dcs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  // address decode: upper bit picks slot space, next bit picks word B
  assign slot_sel = reg_addr[AW-1];
  assign half_b   = reg_addr[AW-2];
  assign addr_idx = reg_addr[IDX_W-1:0];
  assign wr_ok    = reg_wr && !busy;
  assign wr_a     = wr_ok && slot_sel && !half_b;
  assign wr_b     = wr_ok && slot_sel &&  half_b;
  assign wr_ctrl  = wr_ok && !slot_sel && (reg_addr == AW'(CTRL_ADDR));
  assign wr_issue = wr_ok && !slot_sel && (reg_addr == AW'(ISSUE_ADDR));
  assign start    = wr_ctrl && reg_wdata[0] && issue_valid_q;

  dcs_slot_store #(.SLOTS(SLOTS), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_a    (wr_a),
    .wr_b    (wr_b),
    .wr_idx  (addr_idx),
    .wdata   (reg_wdata),
    .bus_idx (addr_idx),
    .seq_idx (seq_idx),
    .bus_a   (bus_a),
    .bus_b   (bus_b),
    .seq_a   (seq_a),
    .seq_b   (seq_b)
  );

  dcs_delay_timer #(.W(DLY_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (tmr_load),
    .load_val (seq_b[DW-1:LO_W]),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  dcs_seq_fsm #(.SLOTS(SLOTS)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start    (start),
    .last_idx (last_q),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_dec  (tmr_dec),
    .idx      (seq_idx),
    .strobe   (cmd_strobe),
    .finish   (finish),
    .busy     (busy)
  );

  // control register
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctrl_start_q <= 1'b0;
      ctrl_done_q  <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_start_q <= reg_wdata[0];
      ctrl_done_q  <= reg_wdata[1];
    end
  end

  // issue register: valid self-clears at the end of a run
  always_comb begin
    valid_en = wr_issue || finish;
    valid_d  = finish ? 1'b0 : reg_wdata[VALID_BIT];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      last_q        <= '0;
      issue_valid_q <= 1'b0;
    end else begin
      if (wr_issue) last_q        <= reg_wdata[IDX_W-1:0];
      if (valid_en) issue_valid_q <= valid_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (slot_sel) begin
      reg_rdata = half_b ? bus_b : bus_a;
    end else begin
      unique case (reg_addr)
        AW'(CTRL_ADDR):   reg_rdata = DW'({ctrl_done_q, ctrl_start_q});
        AW'(ISSUE_ADDR): begin
          reg_rdata[IDX_W-1:0]  = last_q;
          reg_rdata[VALID_BIT]  = issue_valid_q;
        end
        AW'(STATUS_ADDR): reg_rdata[0] = busy;
        default:          reg_rdata = '0;
      endcase
    end
  end

  assign cmd_pins    = cmd_strobe ? seq_a[PIN_W-1:0] : PIN_NOP;
  assign cmd_addr_hi = cmd_strobe ? seq_a[DW-1:PIN_W] : '0;
  assign cmd_addr_lo = cmd_strobe ? seq_b[LO_W-1:0]   : '0;
  assign traffic_en  = ctrl_done_q && !busy;
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker
  import dcs_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        strobe,
  input logic [23:0] pins,
  input logic        traffic_en,
  input logic        valid
);
  AST_STROBE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> busy);  // R3
  AST_NOP_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> (pins == PIN_NOP));  // R4
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);  // R4
  AST_TRAFFIC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !traffic_en);  // R7
  AST_VALID_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> valid);  // R5
  AST_END_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !valid);  // R5
endmodule

bind dram_cmd_seq dcs_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .strobe     (cmd_strobe),
  .pins       (cmd_pins),
  .traffic_en (traffic_en),
  .valid      (issue_valid_q)
);

// File: tb/sim_dram_cmd_seq.sv
module sim_dram_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] NOP = 24'hFFFFFF;

  logic        clk, rst_n, reg_wr;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        cmd_strobe, busy, traffic_en;
  logic [23:0] cmd_pins;
  logic [7:0]  cmd_addr_hi;
  logic [10:0] cmd_addr_lo;

  int checks, failures, cycles;
  int dly [16];
  logic [31:0] wa [16];
  logic [31:0] wb [16];

  dram_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_strobe(cmd_strobe),
    .cmd_pins(cmd_pins), .cmd_addr_hi(cmd_addr_hi), .cmd_addr_lo(cmd_addr_lo),
    .busy(busy), .traffic_en(traffic_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic load_slot(input int s, input int d);
    wa[s]  = {8'hA0 + 8'(s), 24'hFFF000 | 24'(s)};
    wb[s]  = {21'(d), 11'(s * 37 + 5)};
    dly[s] = d;
    wr(6'h20 + 6'(s), wa[s]);
    wr(6'h30 + 6'(s), wb[s]);
  endtask

  // plays the expected schedule clock by clock after the start write
  task automatic run_check(input int last, input string tag);
    logic [31:0] r;
    wr(6'd1, 32'h10 | 32'(last));
    wr(6'd0, 32'h1);
    for (int s = 0; s <= last; s++) begin
      chk(cmd_strobe === 1'b1, {tag, " R3 strobe"}, 32'(cmd_strobe), 1);
      chk(cmd_pins === wa[s][23:0], {tag, " R3 pins"}, 32'(cmd_pins), 32'(wa[s][23:0]));
      chk(cmd_addr_hi === wa[s][31:24], {tag, " R3 addr_hi"}, 32'(cmd_addr_hi), 32'(wa[s][31:24]));
      chk(cmd_addr_lo === wb[s][10:0], {tag, " R3 addr_lo"}, 32'(cmd_addr_lo), 32'(wb[s][10:0]));
      rd(6'd1, r);
      chk(r[4] === 1'b1 && busy === 1'b1, {tag, " R5 valid in run"}, r, 32'h10);
      chk(traffic_en === 1'b0, {tag, " R7 held in run"}, 32'(traffic_en), 0);
      for (int j = 0; j <= dly[s]; j++) begin
        @(negedge clk);
        chk(cmd_strobe === 1'b0 && cmd_pins === NOP && busy === 1'b1,
            {tag, " R4 wait"}, {7'b0, cmd_strobe, cmd_pins}, {8'b0, NOP});
      end
      @(negedge clk);
    end
    chk(busy === 1'b0 && cmd_strobe === 1'b0, {tag, " R5 end busy"}, 32'(busy), 0);
    rd(6'd1, r);
    chk(r === 32'(last), {tag, " R5 valid cleared"}, r, 32'(last));
    rd(6'd2, r);
    chk(r === 32'h0, {tag, " R5 status"}, r, 0);
  endtask

  task automatic t_reset;
    logic [31:0] r;
    chk(busy === 1'b0 && traffic_en === 1'b0 && cmd_strobe === 1'b0,
        "R1 outputs", {busy, traffic_en, cmd_strobe}, 0);
    chk(cmd_pins === NOP, "R1 pins", 32'(cmd_pins), 32'(NOP));
    rd(6'd0, r); chk(r === 0, "R1 ctrl", r, 0);
    rd(6'd1, r); chk(r === 0, "R1 issue", r, 0);
  endtask

  task automatic t_readback;
    logic [31:0] r;
    wr(6'h25, 32'hDEAD_BEEF);
    wr(6'h35, 32'h1234_5678);
    rd(6'h25, r); chk(r === 32'hDEAD_BEEF, "R2 word A", r, 32'hDEAD_BEEF);
    rd(6'h35, r); chk(r === 32'h1234_5678, "R2 word B", r, 32'h1234_5678);
  endtask

  task automatic t_no_valid;
    wr(6'd1, 32'h2);
    wr(6'd0, 32'h1);
    chk(busy === 1'b0 && cmd_strobe === 1'b0, "R8 no start", {busy, cmd_strobe}, 0);
    @(negedge clk);
    chk(busy === 1'b0 && cmd_pins === NOP, "R8 still idle", 32'(busy), 0);
    wr(6'd0, 32'h0);
  endtask

  task automatic t_run3;
    load_slot(0, 0);
    load_slot(1, 3);
    load_slot(2, 1);
    run_check(2, "run3");
  endtask

  task automatic t_single;
    load_slot(0, 5);
    run_check(0, "single");
  endtask

  task automatic t_full;
    for (int s = 0; s < 16; s++) load_slot(s, s % 3);
    run_check(15, "full");
  endtask

  task automatic t_locked;
    logic [31:0] r;
    load_slot(0, 9);
    wr(6'd1, 32'h10);
    wr(6'd0, 32'h1);
    chk(busy === 1'b1, "R6 running", 32'(busy), 1);
    wr(6'h20, 32'h0000_0000);
    wr(6'd1, 32'h1F);
    wr(6'd0, 32'h2);
    for (int k = 0; k < 50 && busy; k++) @(negedge clk);
    rd(6'h20, r); chk(r === wa[0], "R6 slot kept", r, wa[0]);
    rd(6'd1, r);  chk(r === 32'h0, "R6 issue kept", r, 0);
    rd(6'd0, r);  chk(r === 32'h1, "R6 ctrl kept", r, 1);
    chk(traffic_en === 1'b0, "R7 no done", 32'(traffic_en), 0);
  endtask

  task automatic t_traffic;
    wr(6'd0, 32'h3);
    chk(traffic_en === 1'b1, "R7 done sets enable", 32'(traffic_en), 1);
    wr(6'd0, 32'h0);
    chk(traffic_en === 1'b0, "R7 done cleared", 32'(traffic_en), 0);
  endtask

  initial begin
    checks = 0; failures = 0; cycles = 0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_readback;
    t_no_valid;
    t_run3;
    t_single;
    t_locked;
    t_traffic;
    t_full;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule